// File: doc/BRIEF.md
# Configuration Block Receiver

This block takes a stream of bytes from a host, one byte per valid strobe, and assembles a fixed-length settings block from it. Nothing is accepted until the host sends the arming command byte twice in a row. After that, each following byte is written into a staging register file. The final byte of the block is a check code. A millisecond tick times the gap between bytes, and a gap that is too long abandons the load.

When the last byte arrives, the block compares the check byte with a CRC-8 it has computed over the data bytes. One byte value is reserved to skip that comparison. If the load passes, the staged data becomes the active settings in a single cycle, and a write request tells the storage controller to copy the block into external EEPROM when one is fitted. If the load fails, by mismatch or by timeout, the active settings keep their current value. That value is either the power-on defaults or whatever the EEPROM controller last preloaded.

Top module: `cfg_block_loader`

## Requirements
- R1: After reset, `active_cfg` holds the default settings (byte i = (29*i + 17) mod 256, byte i at bits [8i+7:8i]), and `loading`, `done`, `pass` and `ee_write_req` are low.
- R2: Two consecutive accepted bytes equal to 0x01 arm the receiver, and `loading` is high from the cycle after the second one. `loading` goes low in the cycle that `done` pulses.
- R3: A byte other than 0x01 that arrives after a single 0x01 returns the receiver to idle. The next 0x01 then counts only as a first prefix byte.
- R4: While loading, a run of 100 `tick_ms` cycles with no accepted byte ends the load as a failure, and `done` pulses with `pass` low in the following cycle. A run of 99 ticks does not end the load. Any accepted byte restarts the count.
- R5: A failed load leaves `active_cfg` unchanged.
- R6: The block is 35 data bytes followed by one check byte. The check passes when the check byte equals the CRC-8 of the data bytes (polynomial 0x07, initial value 0x00, MSB first, bytes in arrival order).
- R7: A check byte of 0xD6 passes regardless of the data.
- R8: Any other check byte that differs from the CRC fails the load.
- R9: On a pass, `active_cfg` takes the received data in the same cycle that `done` rises. The first data byte goes to bits [7:0].
- R10: `ee_write_req` pulses together with a passing `done` exactly when `ee_present` is high.
- R11: A cycle with `ee_load_valid` high copies `ee_load_cfg` into `active_cfg` at the next edge. A committing load in the same cycle takes precedence.
- R12: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| rx_valid | input | 1 | Byte strobe from the serial front end |
| rx_byte | input | 8 | Received byte |
| ee_present | input | 1 | An external EEPROM is fitted |
| ee_load_valid | input | 1 | Preload settings read from EEPROM |
| ee_load_cfg | input | 280 | Settings read from EEPROM |
| active_cfg | output | 280 | Settings in force |
| loading | output | 1 | Block reception in progress |
| done | output | 1 | Load finished (pulse) |
| pass | output | 1 | Status qualifying `done` |
| ee_write_req | output | 1 | Request to copy the committed block to EEPROM |

## Verification
The assertions assume that `ee_load_valid` is never high in the cycle a load fails, unless the change it causes is allowed for. They also assume that `tick_ms` and `rx_valid` are single-cycle strobes sampled on the clock. The stimulus only drives inputs at the falling edge. It keeps consecutive 0x01 values out of the data wherever arming is not intended, and it issues EEPROM preloads only while no block is in flight. The gap boundary is exercised at exactly 99 and 100 ticks.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ARMED = 2'd1,
        LD_BLOCK = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic done;
        logic pass;
        logic ee_wr;
    } ld_result_t;

    // Power-on value of one settings byte.
    function automatic logic [7:0] default_byte(input int unsigned i);
        return 8'((i * 29) + 17);
    endfunction

    // One byte of a CRC-8, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] data,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ data;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/cfgld_gap_timer.sv
module cfgld_gap_timer #(
    parameter int GAP_LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(GAP_LIMIT + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(GAP_LIMIT - 1);

    logic [CW-1:0] cnt;

    assign expired = run && !clear && tick && (cnt == LIM_M1);

    always_ff @(posedge clk) begin
        if (rst || !run || clear) begin
            cnt <= '0;
        end else if (tick && !expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_gap_bounded_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(GAP_LIMIT));

    p_clear_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        (run && clear) |=> (cnt == '0));

endmodule

// File: rtl/cfgld_crc8.sv
module cfgld_crc8 #(
    parameter logic [7:0] POLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] data,
    output logic [7:0] crc_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= 8'h00;
        end else if (en) begin
            crc_q <= cfgld_pkg::crc8_step(crc_q, data, POLY);
        end
    end

    p_crc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !clear) |=> $stable(crc_q));

endmodule

// File: rtl/cfgld_stage_regs.sv
module cfgld_stage_regs #(
    parameter int DATA_BYTES = 35,
    parameter int IDX_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [7:0]              din,
    output logic [DATA_BYTES*8-1:0] stage_cfg
);
    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_cfg[g*8 +: 8] <= 8'h00;
            end else if (we && (idx == IDX_W'(g))) begin
                stage_cfg[g*8 +: 8] <= din;
            end
        end
    end

endmodule

// File: rtl/cfg_block_loader.sv
module cfg_block_loader #(
    parameter int         DATA_BYTES = 35,
    parameter int         GAP_LIMIT  = 100,
    parameter logic [7:0] CMD_BYTE   = 8'h01,
    parameter logic [7:0] SKIP_CODE  = 8'hD6,
    parameter logic [7:0] CRC_POLY   = 8'h07
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick_ms,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_byte,
    input  logic                    ee_present,
    input  logic                    ee_load_valid,
    input  logic [DATA_BYTES*8-1:0] ee_load_cfg,
    output logic [DATA_BYTES*8-1:0] active_cfg,
    output logic                    loading,
    output logic                    done,
    output logic                    pass,
    output logic                    ee_write_req
);
    import cfgld_pkg::*;

    localparam int CFG_W = DATA_BYTES * 8;
    localparam int IDX_W = $clog2(DATA_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BYTES);

    ld_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [7:0]        crc_q;
    logic [CFG_W-1:0]  stage_cfg;
    logic [CFG_W-1:0]  dflt_cfg;
    logic              expired;
    logic              in_block;
    logic              data_wr;
    logic              last_byte;
    logic              check_ok;
    logic              commit;
    logic              finish;
    ld_result_t        res_q;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_dflt
        assign dflt_cfg[g*8 +: 8] = default_byte(g);
    end

    always_comb begin
        in_block  = (state == LD_BLOCK);
        data_wr   = in_block && rx_valid && (idx < LAST_IDX);
        last_byte = in_block && rx_valid && (idx == LAST_IDX);
        check_ok  = (rx_byte == crc_q) || (rx_byte == SKIP_CODE);
        commit    = last_byte && check_ok;
        finish    = last_byte || expired;
    end

    cfgld_gap_timer #(.GAP_LIMIT(GAP_LIMIT)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .run     (in_block),
        .clear   (rx_valid),
        .tick    (tick_ms),
        .expired (expired)
    );

    cfgld_crc8 #(.POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_block),
        .en    (data_wr),
        .data  (rx_byte),
        .crc_q (crc_q)
    );

    cfgld_stage_regs #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .we        (data_wr),
        .idx       (idx),
        .din       (rx_byte),
        .stage_cfg (stage_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LD_IDLE;
            idx   <= '0;
            res_q <= '0;
        end else begin
            res_q.done  <= finish;
            res_q.pass  <= commit;
            res_q.ee_wr <= commit && ee_present;
            unique case (state)
                LD_IDLE: begin
                    if (rx_valid && (rx_byte == CMD_BYTE)) state <= LD_ARMED;
                end
                LD_ARMED: begin
                    idx <= '0;
                    if (rx_valid) state <= (rx_byte == CMD_BYTE) ? LD_BLOCK : LD_IDLE;
                end
                LD_BLOCK: begin
                    if (finish)        state <= LD_IDLE;
                    else if (rx_valid) idx   <= idx + 1'b1;
                end
                default: state <= LD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_cfg <= dflt_cfg;
        end else if (commit) begin
            active_cfg <= stage_cfg;
        end else if (ee_load_valid) begin
            active_cfg <= ee_load_cfg;
        end
    end

    assign loading      = in_block;
    assign done         = res_q.done;
    assign pass         = res_q.pass;
    assign ee_write_req = res_q.ee_wr;

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_after_done_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !loading);

    p_keep_on_fail_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !pass && !$past(ee_load_valid)) |-> (active_cfg == $past(active_cfg)));

    p_pass_needs_done_r9: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    p_ee_write_r10: assert property (@(posedge clk) disable iff (rst)
        ee_write_req |-> (done && pass && $past(ee_present)));

    p_ee_write_due_r10: assert property (@(posedge clk) disable iff (rst)
        (done && pass && $past(ee_present)) |-> ee_write_req);

endmodule

// File: tb/sim_cfg_block_loader.sv
module sim_cfg_block_loader;
    localparam int NB = 35;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick_ms = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_byte = 8'h00;
    logic            ee_present = 1'b0;
    logic            ee_load_valid = 1'b0;
    logic [NB*8-1:0] ee_load_cfg = '0;
    logic [NB*8-1:0] active_cfg;
    logic            loading, done, pass, ee_write_req;

    int    tests_run = 0;
    int    tests_failed = 0;
    int    dones_seen = 0;
    bit    last_pass = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    cfg_block_loader u0 (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .ee_present(ee_present), .ee_load_valid(ee_load_valid),
        .ee_load_cfg(ee_load_cfg), .active_cfg(active_cfg), .loading(loading),
        .done(done), .pass(pass), .ee_write_req(ee_write_req)
    );

    // ---------------- behavioural reference ----------------
    int       m_st = 0;       // 0 idle, 1 one prefix seen, 2 receiving
    int       m_cnt = 0;
    int       m_gap = 0;
    bit [7:0] m_buf[NB];
    bit [7:0] m_act[NB];
    bit       m_done = 0, m_pass = 0, m_ewr = 0;

    function automatic bit [7:0] crc_ref(input bit [7:0] d[NB]);
        int c = 0;
        foreach (d[i]) begin
            c = c ^ int'(d[i]);
            for (int k = 0; k < 8; k++) begin
                if ((c & 'h80) != 0) c = ((c << 1) ^ 'h07) & 'hFF;
                else                 c = (c << 1) & 'hFF;
            end
        end
        return 8'(c);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_gap = 0;
            m_done = 0; m_pass = 0; m_ewr = 0;
            for (int i = 0; i < NB; i++) m_act[i] = 8'((29 * i + 17) % 256);
        end else begin
            m_done = 0; m_pass = 0; m_ewr = 0;
            case (m_st)
                0: if (rx_valid && rx_byte == 8'h01) m_st = 1;
                1: if (rx_valid) begin
                       if (rx_byte == 8'h01) begin m_st = 2; m_cnt = 0; m_gap = 0; end
                       else m_st = 0;
                   end
                default: begin
                    if (rx_valid) begin
                        m_gap = 0;
                        if (m_cnt < NB) begin
                            m_buf[m_cnt] = rx_byte;
                            m_cnt++;
                        end else begin
                            m_done = 1;
                            m_pass = (rx_byte == crc_ref(m_buf)) || (rx_byte == 8'hD6);
                            if (m_pass) begin
                                m_act = m_buf;
                                m_ewr = ee_present;
                            end
                            m_st = 0;
                        end
                    end else if (tick_ms) begin
                        if (m_gap == 99) begin m_done = 1; m_st = 0; end
                        else m_gap++;
                    end
                end
            endcase
            if (!(m_done && m_pass) && ee_load_valid)
                for (int i = 0; i < NB; i++) m_act[i] = ee_load_cfg[i*8 +: 8];
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!rst && !finished) begin
            tests_run++;
            if (loading !== (m_st == 2) || done !== m_done || pass !== m_pass ||
                ee_write_req !== m_ewr) begin
                tests_failed++;
                $display("FAIL %s flags: got loading=%0b done=%0b pass=%0b ewr=%0b exp %0b %0b %0b %0b",
                         cur_req, loading, done, pass, ee_write_req, (m_st == 2), m_done, m_pass, m_ewr);
            end
            tests_run++;
            for (int i = 0; i < NB; i++) begin
                if (active_cfg[i*8 +: 8] !== m_act[i]) begin
                    tests_failed++;
                    $display("FAIL %s active byte %0d: got %02h exp %02h",
                             cur_req, i, active_cfg[i*8 +: 8], m_act[i]);
                    break;
                end
            end
            if (done === 1'b1) begin dones_seen++; last_pass = pass; end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic put_byte(input logic [7:0] b, input int ticks);
        for (int t = 0; t < ticks; t++) begin
            @(negedge clk); tick_ms = 1'b1;
        end
        @(negedge clk); tick_ms = 1'b0; rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int t = 0; t < n; t++) @(negedge clk);
    endtask

    task automatic expect_outcome(input string req, input int d0, input int exp_dones,
                                  input bit exp_pass);
        tests_run++;
        if ((dones_seen - d0) != exp_dones || (exp_dones > 0 && last_pass != exp_pass)) begin
            tests_failed++;
            $display("FAIL %s outcome: got dones=%0d pass=%0b exp dones=%0d pass=%0b",
                     req, dones_seen - d0, last_pass, exp_dones, exp_pass);
        end
    endtask

    function automatic bit [7:0] pat(input int kind, input int i);
        case (kind)
            0:       return 8'(i * 7 + 3);
            1:       return 8'(i) ^ 8'hA5;
            default: return 8'(8'h10 + i);
        endcase
    endfunction

    task automatic send_block(input int kind, input int chk_mode, input int gap_at,
                              input int gap_ticks);
        bit [7:0] d[NB];
        bit [7:0] c;
        for (int i = 0; i < NB; i++) d[i] = pat(kind, i);
        c = crc_ref(d);
        if (chk_mode == 1) c = 8'hD6;
        if (chk_mode == 2) c = ((c ^ 8'hFF) == 8'hD6) ? (c ^ 8'h01) : (c ^ 8'hFF);
        put_byte(8'h01, 0);
        put_byte(8'h01, 0);
        for (int i = 0; i < NB; i++) put_byte(d[i], (i == gap_at) ? gap_ticks : 1);
        put_byte(c, 2);
        idle(3);
    endtask

    // ---------------- sequence ----------------
    initial begin
        int d0;
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(2);
        cur_req = "R1";
        tests_run++;
        if (loading !== 1'b0 || done !== 1'b0 || active_cfg[7:0] !== 8'h11 ||
            active_cfg[15:8] !== 8'h2E) begin
            tests_failed++;
            $display("FAIL R1 reset: got cfg0=%02h cfg1=%02h exp 11 2e", active_cfg[7:0], active_cfg[15:8]);
        end

        cur_req = "R6/R9/R10 good CRC, eeprom fitted, 99-tick gap R4";
        ee_present = 1'b1; d0 = dones_seen;
        send_block(0, 0, 10, 99);
        expect_outcome("R6", d0, 1, 1'b1);

        cur_req = "R7 skip code";
        ee_present = 1'b0; d0 = dones_seen;
        send_block(1, 1, -1, 0);
        expect_outcome("R7", d0, 1, 1'b1);

        cur_req = "R8/R5 bad check byte";
        ee_present = 1'b1; d0 = dones_seen;
        send_block(2, 2, -1, 0);
        expect_outcome("R8", d0, 1, 1'b0);

        cur_req = "R4/R5 100-tick gap";
        d0 = dones_seen;
        put_byte(8'h01, 0); put_byte(8'h01, 0);
        for (int i = 0; i < 5; i++) put_byte(pat(2, i), 0);
        for (int t = 0; t < 100; t++) begin @(negedge clk); tick_ms = 1'b1; end
        @(negedge clk); tick_ms = 1'b0;
        idle(3);
        expect_outcome("R4", d0, 1, 1'b0);

        cur_req = "R3 broken prefix";
        d0 = dones_seen;
        put_byte(8'h01, 0); put_byte(8'h05, 0);
        for (int i = 0; i < NB + 1; i++) put_byte(pat(0, i), 0);
        idle(2);
        tests_run++;
        if (loading !== 1'b0) begin
            tests_failed++;
            $display("FAIL R3 loading: got %0b exp 0", loading);
        end
        expect_outcome("R3", d0, 0, 1'b0);

        cur_req = "R11 eeprom preload";
        for (int i = 0; i < NB; i++) ee_load_cfg[i*8 +: 8] = 8'(8'hC0 + i);
        @(negedge clk); ee_load_valid = 1'b1;
        @(negedge clk); ee_load_valid = 1'b0;
        tests_run++;
        if (active_cfg[7:0] !== 8'hC0) begin
            tests_failed++;
            $display("FAIL R11 cfg0: got %02h exp c0", active_cfg[7:0]);
        end

        cur_req = "R5 fail keeps preloaded";
        d0 = dones_seen;
        send_block(2, 2, -1, 0);
        expect_outcome("R5", d0, 1, 1'b0);

        cur_req = "R2/R12 second good block";
        d0 = dones_seen;
        send_block(1, 0, 30, 50);
        expect_outcome("R2", d0, 1, 1'b1);
        idle(4);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            tests_run++; tests_failed++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

endmodule